// File: doc/BRIEF.md
# Hidden Command Register Unlock Sequencer

This block sits on the host register bus of a video DAC. It lets a hidden command register share one bus address with the pixel mask register. The block counts consecutive reads of the mask address. Once the count reaches `UNLOCK_READS`, the sequencer is open, and the next read or write at the mask address reaches the hidden command register instead of the mask. That single access closes the sequencer again. Accesses to the other three palette-group addresses clear the count. Addresses outside the palette group are ignored.

A parameter selects the identification variant. In that variant, the last read of the unlock run returns a fixed identification byte instead of the mask value. A second parameter keeps the sequencer open across reads of the hidden register, so that only a write closes it. Read data is combinational and valid in the cycle the read strobe is high. Register updates take effect at the clock edge that ends the access.

Top module: `hidden_cmd_unlock`

## Requirements
- R1: After reset, `cmd_q` is 8'h00, `mask_q` is 8'hFF, the read count is zero, and the sequencer is locked.
- R2: While locked, a read at the mask address (2) returns `mask_q`, except in the case described by R3. A read of any other address returns 8'h00.
- R3: With `ID_ON_FOURTH`=1, the `UNLOCK_READS`-th consecutive mask read (the fourth, by default) returns `ID_BYTE` instead of the mask. With `ID_ON_FOURTH`=0 it returns the mask.
- R4: After `UNLOCK_READS` consecutive mask reads, the next mask-address access reaches the hidden register. A write loads `cmd_q` and leaves `mask_q` unchanged. A read returns `cmd_q`.
- R5: A write to the hidden register always relocks the sequencer. With `READ_KEEPS_OPEN`=0, a read of the hidden register also relocks it. After relocking, a full new run of mask reads is needed to reach the hidden register again.
- R6: Any read or write at palette addresses 0, 1 or 3 clears the count and relocks the sequencer.
- R7: Accesses at addresses 4 and above neither advance nor clear the count.
- R8: A write to the mask address while locked loads `mask_q`, leaves `cmd_q` unchanged, and clears the count.
- R9: With `READ_KEEPS_OPEN`=1, reads of the hidden register keep the sequencer open, so repeated reads all return `cmd_q`. A write still relocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | ADDR_W | Register address of the current access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for the current read |
| cmd_q | output | 8 | Hidden command register value |
| mask_q | output | 8 | Pixel mask register value |

## Verification
The assertions assume that a read strobe and a write strobe are never high in the same cycle. Under that assumption, each strobe cycle is one complete bus access, and idle cycles carry no meaning. The stimulus drives every access through a single task that raises exactly one strobe for one cycle. That task is used for both the directed unlock scenarios and a pseudo-random access stream of a few thousand operations. The stream is biased toward the mask address, so that unlock runs, interruptions and relocks all occur often. Two instances share the stimulus: one uses the identification variant with relock on read, the other uses neither.

// File: rtl/hidden_cmd_unlock.sv
module hidden_cmd_unlock #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 2,
  parameter int UNLOCK_READS = 4,
  parameter logic [7:0] ID_BYTE = 8'hC7,
  parameter bit ID_ON_FOURTH = 1'b1,
  parameter bit READ_KEEPS_OPEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [7:0]        cmd_q,
  output logic [7:0]        mask_q
);
  localparam int CW = $clog2(UNLOCK_READS + 1);
  localparam logic [CW-1:0] OPEN_CNT = CW'(UNLOCK_READS);
  localparam logic [CW-1:0] LAST_CNT = CW'(UNLOCK_READS - 1);

  logic [CW-1:0] cnt;
  logic at_mask, in_group, open;

  assign at_mask  = (reg_sel == MASK_ADDR);
  assign in_group = (reg_sel < ADDR_W'(4));
  assign open     = (cnt == OPEN_CNT);

  always_comb begin
    rd_data = 8'h00;
    if (rd_en && at_mask) begin
      if (open)                             rd_data = cmd_q;
      else if (ID_ON_FOURTH && cnt == LAST_CNT) rd_data = ID_BYTE;
      else                                  rd_data = mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mask_q <= 8'hFF;
      cmd_q  <= 8'h00;
    end else if (wr_en) begin
      if (at_mask) begin
        if (open) cmd_q  <= wr_data;
        else      mask_q <= wr_data;
        cnt <= '0;
      end else if (in_group) begin
        cnt <= '0;
      end
    end else if (rd_en) begin
      if (at_mask) begin
        if (!open)                 cnt <= cnt + CW'(1);
        else if (!READ_KEEPS_OPEN) cnt <= '0;
      end else if (in_group) begin
        cnt <= '0;
      end
    end
  end

  // input rule: one strobe per cycle
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && wr_en));

  // R4
  hidden_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_mask && open) |=> (cmd_q == $past(wr_data) && $stable(mask_q)));

  // R8
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_mask && !open) |=> (mask_q == $past(wr_data) && $stable(cmd_q) && cnt == '0));

  // R6
  group_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && in_group && !at_mask) |=> (cnt == '0));

  // R7
  outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && !in_group) |=> $stable(cnt));

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open && at_mask && (wr_en || (rd_en && !READ_KEEPS_OPEN))) |=> !open);

  // R9
  keep_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (READ_KEEPS_OPEN && open && at_mask && rd_en && !wr_en) |=> open);
endmodule

// File: tb/hidden_cmd_unlock_test.sv
module hidden_cmd_unlock_test;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [3:0] reg_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd0, rd1, cmd0, cmd1, mask0, mask1;
  int checks = 0, fails = 0;

  always #2ns clk = ~clk;

  hidden_cmd_unlock #(.ID_ON_FOURTH(1'b1), .READ_KEEPS_OPEN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd0), .cmd_q(cmd0), .mask_q(mask0));

  hidden_cmd_unlock #(.ID_ON_FOURTH(1'b0), .READ_KEEPS_OPEN(1'b1)) uut_keep (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd1), .cmd_q(cmd1), .mask_q(mask1));

  // bench model: index 0 = ID variant, relock on read; index 1 = no ID, read keeps open
  int  m_cnt [2];
  logic [7:0] m_mask [2], m_cmd [2];
  bit cfg_id [2] = '{1'b1, 1'b0};
  bit cfg_keep [2] = '{1'b0, 1'b1};

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dut_rd(int k);
    return k == 0 ? rd0 : rd1;
  endfunction

  task automatic access(bit is_wr, logic [3:0] a, logic [7:0] d);
    string rtag [2];
    string wtag [2];
    @(negedge clk);
    reg_sel = a; wr_data = d; rd_en = !is_wr; wr_en = is_wr;
    #1ns;
    for (int k = 0; k < 2; k++) begin
      logic [7:0] exp;
      wtag[k] = "R8";
      if (a == 2) begin
        if (m_cnt[k] == 4) begin exp = m_cmd[k]; rtag[k] = cfg_keep[k] ? "R9" : "R4"; wtag[k] = "R4"; end
        else if (m_cnt[k] == 3 && cfg_id[k]) begin exp = 8'hC7; rtag[k] = "R3"; end
        else begin exp = m_mask[k]; rtag[k] = (m_cnt[k] == 3) ? "R3" : "R2"; end
      end else begin
        exp = 8'h00; rtag[k] = "R2";
      end
      if (!is_wr) check(rtag[k], dut_rd(k), exp);
      if (is_wr) begin
        if (a == 2) begin
          if (m_cnt[k] == 4) m_cmd[k] = d; else m_mask[k] = d;
          m_cnt[k] = 0;
        end else if (a < 4) m_cnt[k] = 0;
      end else begin
        if (a == 2) begin
          if (m_cnt[k] < 4) m_cnt[k]++;
          else if (!cfg_keep[k]) m_cnt[k] = 0;
        end else if (a < 4) m_cnt[k] = 0;
      end
      if (a >= 4) wtag[k] = "R7"; else if (a != 2) wtag[k] = "R6";
    end
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    #1ns;
    for (int k = 0; k < 2; k++) begin
      check({wtag[k], " cmd"}, k == 0 ? cmd0 : cmd1, m_cmd[k]);
      check({wtag[k], " mask"}, k == 0 ? mask0 : mask1, m_mask[k]);
    end
  endtask

  task automatic reads(logic [3:0] a, int n);
    for (int i = 0; i < n; i++) access(0, a, 8'h00);
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_mask[k] = 8'hFF; m_cmd[k] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1ns;
    // R1 reset values
    check("R1 cmd", cmd0, 8'h00); check("R1 mask", mask0, 8'hFF);
    check("R1 cmd", cmd1, 8'h00); check("R1 mask", mask1, 8'hFF);
    // R1 locked with zero count: three reads give mask, fourth gives ID on uut
    reads(2, 4);
    access(1, 2, 8'h3C);        // R4 hidden write
    reads(2, 1);                // R5 back to mask (uut), uut_keep relocked by write
    access(1, 2, 8'h00);        // reset count on both
    reads(2, 4); reads(2, 3);   // R9 on uut_keep, R5 on uut
    access(1, 2, 8'h11);        // R9 write relocks uut_keep
    reads(2, 3); access(0, 1, 0); reads(2, 2);   // R6
    reads(2, 3); access(1, 3, 8'h44); reads(2, 1); // R6 write variant
    reads(2, 3); access(0, 9, 0); access(1, 12, 8'h77); reads(2, 2); // R7
    access(1, 2, 8'h5A); reads(2, 3); access(1, 2, 8'hA5); reads(2, 2); // R8
    // pseudo-random sweep
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[3] ? 4'd2 : lfsr[7:4];
      access(lfsr[9:8] == 2'b00, a, lfsr[15:8]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule